// File: doc/BRIEF.md
# Translation Lookaside Buffer with Two-Level Hardware Walker

`mmu_xlat` turns a 32-bit logical address into a physical address of up to 40 bits and checks the access against the rights held in the page tables. An eight-entry fully associative TLB answers a request in one cycle when it holds the page. On a miss, a hardwired walker reads the page tables through a single-read memory port, refills the TLB and then repeats the lookup. Software plays no part in the refill.

Pages are either 4 KB, mapped by a level-2 table, or 2 MB, mapped directly by a level-1 entry. A level-1 entry marked as a large page ends the walk after one read. Each address stream (instruction fetch or data access) uses its own instance.

The client places a request while `req_ready` is high and holds it for one cycle. Exactly one response pulse on `rsp_valid` follows: a translated address, a page fault, or a rights violation.

Top module: `mmu_xlat`

## Requirements
- R1: A request whose page is held in the TLB produces `rsp_valid` in the cycle after acceptance, issues no memory read, and reports the stored translation.
- R2: Table entries are 64 bits, with fields placed as follows. Bit 0 is valid, bit 1 is large page, bit 2 is writable, bit 3 is executable and bit 4 is user. Bits 39:12 hold the frame number. The level-1 entry is read at `pt_root + vaddr[31:21]*8`. When that entry is not a large page, the level-2 entry is read at `{frame,12'h000} + vaddr[20:12]*8`, and the result is `{frame2, vaddr[11:0]}`.
- R3: A valid level-1 entry with bit 1 set ends the walk after one read and maps a 2 MB page: `paddr = {entry[39:21], vaddr[20:0]}`. Any later address inside the same 2 MB region hits.
- R4: A request is refused with `rsp_denied=1` in any of three cases: a write to a page whose writable bit is clear, an execute access to a page whose executable bit is clear, or a user access to a page whose user bit is clear. The check is made on hits as well as after refills.
- R5: An entry with its valid bit clear at either level gives `rsp_fault=1` and installs nothing, so the next access to that page walks again.
- R6: An error response carries `rsp_paddr = 0` and never sets both `rsp_fault` and `rsp_denied`.
- R7: A one-cycle `flush` pulse invalidates every TLB entry, so the next access to any page walks the tables again.
- R8: Refills take TLB slots in round-robin order. After eight refills that follow it, a page is evicted, while the pages of the last eight refills still hit.
- R9: `mem_req` is a one-cycle pulse with `mem_addr` valid in that cycle. Only one read is outstanding at a time, and `req_ready` stays low from a miss until the response.
- R10: After reset the TLB is empty, `req_ready=1`, `rsp_valid=0` and `mem_req=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all TLB entries |
| pt_root | input | 40 | Physical base of the level-1 table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Logical address |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Page fault |
| rsp_denied | output | 1 | Rights violation |
| rsp_paddr | output | 40 | Physical address, zero on error |
| mem_req | output | 1 | Table read pulse |
| mem_addr | output | 40 | Table entry address |
| mem_rvalid | input | 1 | Table read data valid |
| mem_rdata | input | 64 | Table entry |

## Verification
Eviction is the hardest state to reach from the ports. The bench only sees it when a page it hit earlier misses again after exactly eight newer refills, and faulting walks must not advance the replacement pointer. The bench keeps its own eight-slot model of the TLB. It flushes the TLB, fills it with eight directed 4 KB pages plus a ninth, and checks from the number of table reads that the oldest page was the one evicted. Random traffic over a small page pool, with occasional flushes, then keeps hits, misses, faults and evictions interleaved against the model.

// File: rtl/mmu_xlat.sv
`timescale 1ns/1ps
module mmu_xlat #(
  parameter int PA_W    = 40,
  parameter int ENTRIES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [PA_W-1:0] pt_root,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     req_vaddr,
  input  logic            req_write,
  input  logic            req_exec,
  input  logic            req_user,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_denied,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata
);
  localparam int FN_W = PA_W - 12;
  localparam int RR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT, S_RETRY} st_t;
  st_t st;

  logic [31:0]        va_q;
  logic               wr_q, ex_q, us_q;
  logic [FN_W-1:0]    l1fn_q;
  logic [ENTRIES-1:0] vld, tbig, tw, tx, tu;
  logic [19:0]        tvpn [ENTRIES];
  logic [FN_W-1:0]    tfn  [ENTRIES];
  logic [RR_W-1:0]    rr;

  logic        idle, lk_wr, lk_ex, lk_us;
  logic [31:0] lk_va;
  assign idle  = (st == S_IDLE);
  assign lk_va = idle ? req_vaddr : va_q;
  assign lk_wr = idle ? req_write : wr_q;
  assign lk_ex = idle ? req_exec  : ex_q;
  assign lk_us = idle ? req_user  : us_q;

  logic            hit, h_big, h_w, h_x, h_u;
  logic [FN_W-1:0] h_fn;
  always_comb begin
    hit = 1'b0; h_big = 1'b0; h_w = 1'b0; h_x = 1'b0; h_u = 1'b0; h_fn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && (tbig[i] ? (tvpn[i][19:9] == lk_va[31:21]) : (tvpn[i] == lk_va[31:12]))) begin
        hit = 1'b1; h_big = tbig[i]; h_w = tw[i]; h_x = tx[i]; h_u = tu[i]; h_fn = tfn[i];
      end
  end

  logic            deny;
  logic [PA_W-1:0] h_pa;
  assign deny = (lk_wr && !h_w) || (lk_ex && !h_x) || (lk_us && !h_u);
  assign h_pa = h_big ? {h_fn[FN_W-1:9], lk_va[20:0]} : {h_fn, lk_va[11:0]};

  logic            pte_v, pte_big, fill;
  logic [FN_W-1:0] pte_fn;
  logic            unused_bits;
  assign pte_v       = mem_rdata[0];
  assign pte_big     = mem_rdata[1];
  assign pte_fn      = mem_rdata[PA_W-1:12];
  assign unused_bits = ^{mem_rdata[63:PA_W], mem_rdata[11:5]};
  assign fill = mem_rvalid && pte_v && (((st == S_L1WAIT) && pte_big) || (st == S_L2WAIT));

  assign req_ready = idle;
  assign mem_req   = (st == S_L1REQ) || (st == S_L2REQ);
  assign mem_addr  = (st == S_L1REQ) ? pt_root + PA_W'({va_q[31:21], 3'b000})
                                     : {l1fn_q, 12'h000} + PA_W'({va_q[20:12], 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_denied <= 1'b0;
      rsp_paddr <= '0; va_q <= '0; wr_q <= 1'b0; ex_q <= 1'b0; us_q <= 1'b0; l1fn_q <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr; wr_q <= req_write; ex_q <= req_exec; us_q <= req_user;
          if (hit) begin
            rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_denied <= deny;
            rsp_paddr <= deny ? '0 : h_pa;
          end else st <= S_L1REQ;
        end
        S_L1REQ: st <= S_L1WAIT;
        S_L2REQ: st <= S_L2WAIT;
        S_L1WAIT, S_L2WAIT: if (mem_rvalid) begin
          if (!pte_v) begin
            rsp_valid <= 1'b1; rsp_fault <= 1'b1; rsp_denied <= 1'b0;
            rsp_paddr <= '0; st <= S_IDLE;
          end else if (st == S_L1WAIT && !pte_big) begin
            l1fn_q <= pte_fn; st <= S_L2REQ;
          end else st <= S_RETRY;
        end
        S_RETRY: if (hit) begin
          rsp_valid <= 1'b1; rsp_fault <= 1'b0; rsp_denied <= deny;
          rsp_paddr <= deny ? '0 : h_pa; st <= S_IDLE;
        end else st <= S_L1REQ;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; rr <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (fill) begin
      vld[rr] <= 1'b1;
      rr <= (rr == RR_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tvpn[rr] <= va_q[31:12];
      tfn[rr]  <= pte_fn;
      tbig[rr] <= (st == S_L1WAIT);
      tw[rr]   <= mem_rdata[2];
      tx[rr]   <= mem_rdata[3];
      tu[rr]   <= mem_rdata[4];
    end
  end

  a_r1_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && hit) |=> (rsp_valid && !rsp_fault));
  a_r6_one_error_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault && rsp_denied));
  a_r6_error_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault || rsp_denied)) |-> (rsp_paddr == '0));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0));
  a_r9_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r9_busy_during_walk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: tb/sim_mmu_xlat.sv
`timescale 1ns/1ps
module sim_mmu_xlat;
  localparam logic [39:0] ROOT = 40'h01_2340_0000;

  logic        clk = 1'b0;
  logic        rst_n, flush, req_valid, req_write, req_exec, req_user, mem_rvalid;
  logic [31:0] req_vaddr;
  logic [63:0] mem_rdata;
  logic        req_ready, rsp_valid, rsp_fault, rsp_denied, mem_req;
  logic [39:0] rsp_paddr, mem_addr;
  logic [39:0] pt_root = ROOT;

  int n_chk = 0, n_bad = 0, rd_cnt = 0;

  always #4 clk = ~clk;

  mmu_xlat u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_root(pt_root),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_exec(req_exec), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_denied(rsp_denied),
    .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  function automatic logic [63:0] mem_word(input logic [39:0] a);
    logic [10:0] i, t;
    logic [8:0]  j;
    if (a >= ROOT && a < ROOT + 40'd16384) begin
      i = 11'((a - ROOT) >> 3);
      case (i[1:0])
        2'd0:    return 64'h0000_00AB_CDEF_001E;
        2'd1:    return {24'h0, 28'h0300000 + {8'h0, i, 9'h0}, 7'h0, i[4], i[3], i[2], 2'b11};
        default: return {24'h0, 28'h2000000 + {17'h0, i}, 12'h001};
      endcase
    end else if (a[39:23] == 17'h04000) begin
      t = a[22:12]; j = a[11:3];
      if (j[2:0] == 3'd7) return 64'h0000_0012_3456_0016;
      return {24'h0, 8'h45, t, j, 7'h0, j[2] ^ t[0], j[1], j[0], 2'b01};
    end
    return 64'h0;
  endfunction

  logic        mv   [8];
  logic [19:0] mvpn [8];
  logic        mbig [8];
  logic [27:0] mfn  [8];
  logic [2:0]  mfl  [8];
  int          mptr = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int k = 0; k < 8; k++) mv[k] = 1'b0;
  endtask

  task automatic do_xlat(input logic [31:0] va, input logic wr, input logic ex,
                         input logic us, input string tag);
    logic        hitm, e_fault, e_den, big;
    logic [27:0] fn;
    logic [2:0]  fl;
    logic [63:0] e1, e2;
    logic [39:0] e_pa;
    int          e_reads, waited;
    hitm = 1'b0; e_fault = 1'b0; big = 1'b0; fn = '0; fl = '0; e_reads = 0;
    for (int k = 0; k < 8; k++)
      if (mv[k] && (mbig[k] ? (mvpn[k][19:9] == va[31:21]) : (mvpn[k] == va[31:12]))) begin
        hitm = 1'b1; big = mbig[k]; fn = mfn[k]; fl = mfl[k];
      end
    if (!hitm) begin
      e1 = mem_word(ROOT + {26'h0, va[31:21], 3'b000}); e_reads = 1;
      if (!e1[0]) e_fault = 1'b1;
      else if (e1[1]) begin big = 1'b1; fn = e1[39:12]; fl = e1[4:2]; end
      else begin
        e2 = mem_word({e1[39:12], 12'h0} + {28'h0, va[20:12], 3'b000}); e_reads = 2;
        if (!e2[0]) e_fault = 1'b1;
        else begin fn = e2[39:12]; fl = e2[4:2]; end
      end
      if (!e_fault) begin
        mv[mptr] = 1'b1; mvpn[mptr] = va[31:12]; mbig[mptr] = big;
        mfn[mptr] = fn; mfl[mptr] = fl; mptr = (mptr + 1) % 8;
      end
    end
    e_den = !e_fault && ((wr && !fl[0]) || (ex && !fl[1]) || (us && !fl[2]));
    e_pa  = (e_fault || e_den) ? 40'h0 : (big ? {fn[27:9], va[20:0]} : {fn, va[11:0]});

    @(negedge clk);
    req_vaddr = va; req_write = wr; req_exec = ex; req_user = us; req_valid = 1'b1;
    rd_cnt = 0; waited = 0;
    do begin
      @(negedge clk); req_valid = 1'b0; waited++;
    end while (!rsp_valid && waited < 200);

    chk(rsp_valid, tag, "response seen", 64'(rsp_valid), 64'd1);
    chk({rsp_fault, rsp_denied} == {e_fault, e_den}, tag, "fault/denied",
        64'({rsp_fault, rsp_denied}), 64'({e_fault, e_den}));
    chk(rsp_paddr == e_pa, tag, "paddr", 64'(rsp_paddr), 64'(e_pa));
    chk(rd_cnt == e_reads, tag, "table reads (R9 port)", 64'(rd_cnt), 64'(e_reads));
    if (e_fault || e_den) chk(rsp_paddr == 40'h0, "R6", "error paddr", 64'(rsp_paddr), 64'h0);
    if (hitm) chk(waited == 1, "R1", "hit latency", 64'(waited), 64'd1);
  endtask

  logic [39:0] ma;
  initial begin
    mem_rvalid = 1'b0; mem_rdata = '0;
    @(negedge clk);
    forever begin
      if (mem_req) begin
        ma = mem_addr; rd_cnt++;
        repeat (1 + $urandom % 3) @(negedge clk);
        mem_rdata = mem_word(ma); mem_rvalid = 1'b1;
        @(negedge clk); mem_rvalid = 1'b0;
      end else @(negedge clk);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pool [16];
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) mv[k] = 1'b0;
    rst_n = 1'b0; flush = 1'b0; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R10", "ready after reset", 64'(req_ready), 64'd1);
    chk(!rsp_valid, "R10", "no response after reset", 64'(rsp_valid), 64'd0);
    chk(!mem_req, "R10", "no read after reset", 64'(mem_req), 64'd0);

    do_xlat({11'd2, 9'd5, 12'h123}, 1'b0, 1'b0, 1'b0, "R2");
    do_xlat({11'd2, 9'd5, 12'hABC}, 1'b0, 1'b0, 1'b0, "R1");
    do_xlat({11'd1, 21'h1ABCDE}, 1'b0, 1'b0, 1'b0, "R3");
    do_xlat({11'd1, 21'h00F00F}, 1'b0, 1'b0, 1'b0, "R3");
    do_xlat({11'd0, 9'd3, 12'h010}, 1'b0, 1'b0, 1'b0, "R5");
    do_xlat({11'd0, 9'd3, 12'h020}, 1'b0, 1'b0, 1'b0, "R5");
    do_xlat({11'd2, 9'd7, 12'h000}, 1'b0, 1'b0, 1'b0, "R5");
    do_xlat({11'd2, 9'd4, 12'h004}, 1'b1, 1'b0, 1'b0, "R4");
    do_xlat({11'd2, 9'd4, 12'h008}, 1'b0, 1'b1, 1'b0, "R4");
    do_xlat({11'd2, 9'd4, 12'h00C}, 1'b0, 1'b0, 1'b0, "R4");
    do_xlat({11'd6, 9'd0, 12'h000}, 1'b0, 1'b0, 1'b1, "R4");

    do_flush();
    do_xlat({11'd2, 9'd5, 12'h123}, 1'b0, 1'b0, 1'b0, "R7");

    do_flush();
    for (int j = 0; j < 7; j++) do_xlat({11'd2, 9'(j), 12'h040}, 1'b0, 1'b0, 1'b0, "R8");
    do_xlat({11'd3, 9'd0, 12'h040}, 1'b0, 1'b0, 1'b0, "R8");
    do_xlat({11'd2, 9'd1, 12'h080}, 1'b0, 1'b0, 1'b0, "R8");
    do_xlat({11'd3, 9'd1, 12'h040}, 1'b0, 1'b0, 1'b0, "R8");
    do_xlat({11'd2, 9'd0, 12'h0C0}, 1'b0, 1'b0, 1'b0, "R8");
    do_xlat({11'd3, 9'd0, 12'h0C0}, 1'b0, 1'b0, 1'b0, "R8");

    for (int k = 0; k < 16; k++)
      pool[k] = {11'($urandom % 12), 9'($urandom % 10), 12'h000};
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 30 == 0) do_flush();
      do_xlat(pool[$urandom % 16] | 32'($urandom % 4096),
              1'($urandom), 1'($urandom), 1'($urandom), "R4");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule